// File: doc/BRIEF.md
# ISA-Style I/O Port Slave

This block sits on the peripheral side of an 8/16-bit ISA-style expansion bus and answers I/O port cycles. It runs synchronously to the bus clock. It decodes a window of `2*NREGS` bytes at a parameterised base in the 64K port space, using address bits 0 to 15. Reads are served from, and writes land in, a small bank of 16-bit registers. The tristate data buffers are represented by two lane enables, one for each byte lane. The active-low 16-bit capability line follows the address decode alone, so it is valid before any strobe falls.

Cycles that arrive while the DMA address-enable line is high belong to the DMA controller, and the block ignores them completely. Each accepted access is stretched by `WAIT_STATES` bus clocks, during which channel-ready is held low. That count is clamped to 16, so ready is never inactive for more than 17 clocks. The byte-high-enable input chooses which byte lanes carry the transfer. An odd address with byte-high-enable inactive moves the register's upper byte over data bits 0 to 7.

The controller is a three-state machine:
- IDLE: no access in progress. START_WAIT leads to WAIT. START_NOWAIT leads straight to DONE when the wait count is zero.
- WAIT: ready is low. FINISH leads to DONE when the count runs out. ABORT leads back to IDLE if the strobe, the window hit or the address qualification drops first.
- DONE: the transfer has taken effect. RELEASE leads to IDLE once both strobes are high.

Top module: `isa_io_slave`

## Requirements
- R1: `io_cs16_n` is low exactly when `addr_i[15:4]` equals `BASE[15:4]` (default window 0x300 to 0x30F), whatever the strobes and `aen` are doing.
- R2: While `aen` is high, strobes cause no effect: ready stays high, both lane enables stay low and no register changes.
- R3: `data_oe_lo` is high when `ior_n` is low, the address hits and `aen` is low, and either `addr_i[0]`=0 or `sbhe_n`=1. `data_oe_hi` is high under the same read condition with `sbhe_n`=0.
- R3 (lane contents): the high lane carries the register's upper byte. The low lane carries the lower byte for an even address and the upper byte for an odd address.
- R4: The register index is `addr_i[3:1]`. The lane rules for writes are:
  - even address, `sbhe_n`=0: both bytes are written from D15..0.
  - even address, `sbhe_n`=1: the lower byte is written from D7..0.
  - odd address, `sbhe_n`=0: the upper byte is written from D15..8.
  - odd address, `sbhe_n`=1: the upper byte is written from D7..0.
- R5: Ready goes low starting the clock after an accepted strobe. It stays low for exactly min(`WAIT_STATES`,16) clocks and is never low for more than 17 clocks in a row.
- R6: If the strobe is released while ready is low, the access is abandoned. No write occurs and ready returns high on the next clock.
- R7: After reset, ready is high, both lane enables are low and all registers read as zero.
- R8: Strobes to addresses outside the window have no effect on ready, the lane enables or the registers.
- R9: A strobe held low after completion performs no second transfer. A data change during the hold is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_reset | input | 1 | Synchronous reset, active high |
| aen | input | 1 | High while the DMA controller owns the bus |
| addr_i | input | 16 | I/O port address |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| sbhe_n | input | 1 | Byte-high enable, active low |
| data_i | input | 16 | Data from the bus |
| data_o | output | 16 | Data to the bus |
| data_oe_lo | output | 1 | Drive enable for data bits 7..0 |
| data_oe_hi | output | 1 | Drive enable for data bits 15..8 |
| ch_ready_o | output | 1 | Channel ready, low to insert wait states |
| io_cs16_n | output | 1 | Low when the address falls in the 16-bit capable window |

## Verification
The decode line and the lane enables are combinational. The bench samples them one nanosecond after it changes the address or strobe, with no clock edge in between. Ready is a registered output, so it first reads low at the falling edge after the rising edge that accepts the strobe. The bench counts ready-low falling edges up to the first high one, and compares that count with the expected wait count. A write is stored at the edge that moves the machine to DONE. For that reason the bench always confirms a stored or ignored write with a later, separate read access, and never during the same cycle.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } io_state_e;

    // Hard ceiling on inserted wait states; ready low run never exceeds CAP+1.
    localparam int unsigned WAIT_CAP = 16;
    localparam int unsigned READY_LOW_LIMIT = WAIT_CAP + 1;

endpackage

// File: rtl/isa_io_decode.sv
module isa_io_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 3,
    parameter logic [15:0] BASE   = 16'h0300
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              odd_o
);
    localparam int unsigned LSB = IDX_W + 1;

    always_comb begin
        hit_o = (addr_i[ADDR_W-1:LSB] == BASE[ADDR_W-1:LSB]);
        idx_o = addr_i[IDX_W:1];
        odd_o = addr_i[0];
    end

endmodule

// File: rtl/isa_io_fsm.sv
module isa_io_fsm
    import isa_io_pkg::*;
#(
    parameter int unsigned WAIT_STATES = 3
) (
    input  logic bus_clk,
    input  logic bus_reset,
    input  logic go_i,        // qualified strobe: hit, aen low, a strobe low
    input  logic strobe_i,    // any strobe low, unqualified
    input  logic wr_req_i,    // write strobe low
    output logic ready_o,
    output logic commit_o
);
    localparam int unsigned EFF_WAIT = (WAIT_STATES > WAIT_CAP) ? WAIT_CAP : WAIT_STATES;
    localparam int unsigned CNT_W    = 5;
    localparam logic [CNT_W-1:0] LOAD = (EFF_WAIT == 0) ? '0 : CNT_W'(EFF_WAIT - 1);

    io_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q, wr_d;
    logic [5:0]       low_run_q;

    // Next-state and transition logic.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wr_d     = wr_q;
        commit_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) begin
                    wr_d = wr_req_i;
                    if (EFF_WAIT == 0) begin
                        state_d  = ST_DONE;       // START_NOWAIT
                        commit_o = wr_req_i;
                    end else begin
                        state_d = ST_WAIT;        // START_WAIT
                        cnt_d   = LOAD;
                    end
                end
            end
            ST_WAIT: begin
                if (!go_i) begin
                    state_d = ST_IDLE;            // ABORT
                end else if (cnt_q == '0) begin
                    state_d  = ST_DONE;           // FINISH
                    commit_o = wr_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_DONE: begin
                if (!strobe_i) state_d = ST_IDLE; // RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge bus_clk) begin
        if (bus_reset) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
        end
    end

    // Outputs.
    always_comb begin
        ready_o = (state_q != ST_WAIT);
    end

    // Length of the current ready-low run, for the cap check.
    always_ff @(posedge bus_clk) begin
        if (bus_reset)                low_run_q <= '0;
        else if (ready_o)             low_run_q <= '0;
        else if (low_run_q != 6'h3F)  low_run_q <= low_run_q + 1'b1;
    end

    assert_ready_cap_R5: assert property (@(posedge bus_clk) disable iff (bus_reset)
        low_run_q <= 6'(READY_LOW_LIMIT));

    assert_dma_no_start_R2: assert property (@(posedge bus_clk) disable iff (bus_reset)
        (state_q == ST_IDLE && !go_i) |=> (state_q == ST_IDLE));

    assert_abort_idle_R6: assert property (@(posedge bus_clk) disable iff (bus_reset)
        (state_q == ST_WAIT && !go_i) |=> (state_q == ST_IDLE && ready_o));

    assert_single_commit_R9: assert property (@(posedge bus_clk) disable iff (bus_reset)
        (state_q == ST_DONE) |-> !commit_o);

endmodule

// File: rtl/isa_io_regbank.sv
module isa_io_regbank #(
    parameter int unsigned NREGS = 8,
    parameter int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic             bus_clk,
    input  logic             bus_reset,
    input  logic             commit_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             odd_i,
    input  logic             sbhe_n_i,
    input  logic [15:0]      wdata_i,
    output logic [15:0]      rdata_o
);
    logic [NREGS-1:0][15:0] mem_q;
    logic [NREGS-1:0]       wen;
    logic                   wr_lo, wr_hi;
    logic [7:0]             hi_src;

    for (genvar g = 0; g < NREGS; g++) begin : g_wen
        assign wen[g] = commit_i && (idx_i == IDX_W'(g));
    end

    // Byte-lane steering for writes.
    always_comb begin
        wr_lo  = !odd_i;
        wr_hi  = odd_i || !sbhe_n_i;
        hi_src = (odd_i && sbhe_n_i) ? wdata_i[7:0] : wdata_i[15:8];
    end

    always_ff @(posedge bus_clk) begin
        if (bus_reset) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (wen[i] && wr_lo) mem_q[i][7:0]  <= wdata_i[7:0];
                if (wen[i] && wr_hi) mem_q[i][15:8] <= hi_src;
            end
        end
    end

    always_comb begin
        rdata_o[15:8] = mem_q[idx_i][15:8];
        rdata_o[7:0]  = odd_i ? mem_q[idx_i][15:8] : mem_q[idx_i][7:0];
    end

    assert_hold_without_commit_R4: assert property (@(posedge bus_clk) disable iff (bus_reset)
        !commit_i |=> $stable(mem_q));

endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned NREGS       = 8,
    parameter logic [15:0] BASE        = 16'h0300,
    parameter int unsigned WAIT_STATES = 3
) (
    input  logic              bus_clk,
    input  logic              bus_reset,
    input  logic              aen,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              sbhe_n,
    input  logic [15:0]       data_i,
    output logic [15:0]       data_o,
    output logic              data_oe_lo,
    output logic              data_oe_hi,
    output logic              ch_ready_o,
    output logic              io_cs16_n
);
    localparam int unsigned IDX_W = $clog2(NREGS);

    logic             hit, odd, go, strobe, rd_act, commit;
    logic [IDX_W-1:0] idx;

    isa_io_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_decode (
        .addr_i (addr_i),
        .hit_o  (hit),
        .idx_o  (idx),
        .odd_o  (odd)
    );

    always_comb begin
        strobe = !ior_n || !iow_n;
        go     = strobe && hit && !aen;
        rd_act = !ior_n && hit && !aen;
    end

    isa_io_fsm #(.WAIT_STATES(WAIT_STATES)) u_fsm (
        .bus_clk   (bus_clk),
        .bus_reset (bus_reset),
        .go_i      (go),
        .strobe_i  (strobe),
        .wr_req_i  (!iow_n),
        .ready_o   (ch_ready_o),
        .commit_o  (commit)
    );

    isa_io_regbank #(.NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
        .bus_clk   (bus_clk),
        .bus_reset (bus_reset),
        .commit_i  (commit),
        .idx_i     (idx),
        .odd_i     (odd),
        .sbhe_n_i  (sbhe_n),
        .wdata_i   (data_i),
        .rdata_o   (data_o)
    );

    always_comb begin
        io_cs16_n  = !hit;
        data_oe_lo = rd_act && (!odd || sbhe_n);
        data_oe_hi = rd_act && !sbhe_n;
    end

    assert_oe_qualified_R3: assert property (@(posedge bus_clk) disable iff (bus_reset)
        (data_oe_lo || data_oe_hi) |-> (!ior_n && !aen && !io_cs16_n));

    assert_dma_ready_R2: assert property (@(posedge bus_clk) disable iff (bus_reset)
        (aen && $past(aen) && ch_ready_o) |=> ch_ready_o || !aen);

endmodule

// File: tb/isa_io_slave_tb.sv
module isa_io_slave_tb_top;
    localparam int WAITS = 3;

    logic        bus_clk = 1'b0;
    logic        bus_reset = 1'b1;
    logic        aen = 1'b0;
    logic [15:0] addr_i = 16'h0000;
    logic        ior_n = 1'b1, iow_n = 1'b1, sbhe_n = 1'b1;
    logic [15:0] data_i = 16'h0000;
    logic [15:0] data_o;
    logic        data_oe_lo, data_oe_hi, ch_ready_o, io_cs16_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] model [8];

    isa_io_slave #(.WAIT_STATES(WAITS)) dut_i (
        .bus_clk(bus_clk), .bus_reset(bus_reset), .aen(aen), .addr_i(addr_i),
        .ior_n(ior_n), .iow_n(iow_n), .sbhe_n(sbhe_n), .data_i(data_i),
        .data_o(data_o), .data_oe_lo(data_oe_lo), .data_oe_hi(data_oe_hi),
        .ch_ready_o(ch_ready_o), .io_cs16_n(io_cs16_n)
    );

    always #4 bus_clk = ~bus_clk;

    always @(posedge bus_clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired (all R) actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // One complete access; returns ready-low count and the lanes seen at completion.
    task automatic access(input logic wr, input logic sb, input logic [15:0] a,
                          input logic [15:0] d, output int waits,
                          output logic [15:0] rd, output logic olo, output logic ohi);
        addr_i = a; sbhe_n = sb; data_i = d;
        if (wr) iow_n = 1'b0; else ior_n = 1'b0;
        waits = 0;
        @(negedge bus_clk);
        while (!ch_ready_o && waits < 30) begin
            waits++;
            @(negedge bus_clk);
        end
        rd = data_o; olo = data_oe_lo; ohi = data_oe_hi;
        iow_n = 1'b1; ior_n = 1'b1;
        @(negedge bus_clk);
        @(negedge bus_clk);
    endtask

    task automatic check_read(input string tag, input logic [15:0] a, input logic sb);
        int w; logic [15:0] rd; logic olo, ohi;
        logic [15:0] word;
        word = model[a[3:1]];
        access(1'b0, sb, a, 16'h0, w, rd, olo, ohi);
        chk({tag, " R5 waits"}, 16'(w), 16'(WAITS));
        chk({tag, " R3 oe_lo"}, {15'd0, olo}, {15'd0, (!a[0] || sb)});
        chk({tag, " R3 oe_hi"}, {15'd0, ohi}, {15'd0, !sb});
        if (!a[0] || sb) chk({tag, " R3 low lane"}, {8'd0, rd[7:0]}, {8'd0, a[0] ? word[15:8] : word[7:0]});
        if (!sb)         chk({tag, " R3 high lane"}, {8'd0, rd[15:8]}, {8'd0, word[15:8]});
    endtask

    // {is_write, sbhe_n, addr, data}
    localparam logic [33:0] VEC [13] = '{
        {1'b1, 1'b0, 16'h0300, 16'hA1B2},
        {1'b1, 1'b1, 16'h0302, 16'h0055},
        {1'b1, 1'b0, 16'h0303, 16'h7700},
        {1'b1, 1'b1, 16'h0305, 16'h0099},
        {1'b1, 1'b0, 16'h030E, 16'hBEEF},
        {1'b0, 1'b0, 16'h0300, 16'h0000},
        {1'b0, 1'b1, 16'h0301, 16'h0000},
        {1'b0, 1'b0, 16'h0302, 16'h0000},
        {1'b0, 1'b0, 16'h0303, 16'h0000},
        {1'b0, 1'b1, 16'h0304, 16'h0000},
        {1'b0, 1'b1, 16'h0305, 16'h0000},
        {1'b0, 1'b0, 16'h030E, 16'h0000},
        {1'b0, 1'b1, 16'h030F, 16'h0000}
    };

    initial begin
        int w; logic [15:0] rd; logic olo, ohi;
        for (int i = 0; i < 8; i++) model[i] = 16'h0;
        repeat (3) @(negedge bus_clk);
        bus_reset = 1'b0;
        @(negedge bus_clk);

        // R7 reset state
        chk("R7 ready after reset", {15'd0, ch_ready_o}, 16'd1);
        chk("R7 oe after reset", {14'd0, data_oe_hi, data_oe_lo}, 16'd0);
        check_read("R7 reg zero", 16'h0300, 1'b0);

        // R1 decode
        addr_i = 16'h030A; #1 chk("R1 in window", {15'd0, io_cs16_n}, 16'd0);
        addr_i = 16'h0310; #1 chk("R1 above window", {15'd0, io_cs16_n}, 16'd1);
        addr_i = 16'h02FF; #1 chk("R1 below window", {15'd0, io_cs16_n}, 16'd1);
        aen = 1'b1; addr_i = 16'h0300; #1 chk("R1 independent of aen", {15'd0, io_cs16_n}, 16'd0);
        aen = 1'b0;
        @(negedge bus_clk);

        // Vector table: writes then reads against the bench model (R3, R4, R5)
        for (int v = 0; v < 13; v++) begin
            logic [15:0] a, d;
            logic sb;
            a = VEC[v][31:16]; d = VEC[v][15:0]; sb = VEC[v][32];
            if (VEC[v][33]) begin
                access(1'b1, sb, a, d, w, rd, olo, ohi);
                chk("R5 write waits", 16'(w), 16'(WAITS));
                if (!a[0]) model[a[3:1]][7:0] = d[7:0];
                if (a[0] || !sb) model[a[3:1]][15:8] = (a[0] && sb) ? d[7:0] : d[15:8];
            end else begin
                check_read("R4 vector", a, sb);
            end
        end

        // R2 DMA-owned cycles ignored
        aen = 1'b1; addr_i = 16'h0300; sbhe_n = 1'b0; data_i = 16'h1234; iow_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge bus_clk);
            chk("R2 ready under aen write", {15'd0, ch_ready_o}, 16'd1);
        end
        iow_n = 1'b1; ior_n = 1'b0; #1
        chk("R2 oe under aen read", {14'd0, data_oe_hi, data_oe_lo}, 16'd0);
        @(negedge bus_clk);
        chk("R2 ready under aen read", {15'd0, ch_ready_o}, 16'd1);
        ior_n = 1'b1; aen = 1'b0;
        @(negedge bus_clk);
        check_read("R2 reg unchanged", 16'h0300, 1'b0);

        // R8 out-of-window write ignored
        addr_i = 16'h0310; sbhe_n = 1'b0; data_i = 16'h5555; iow_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge bus_clk);
            chk("R8 ready outside window", {15'd0, ch_ready_o}, 16'd1);
        end
        iow_n = 1'b1; ior_n = 1'b0; #1
        chk("R8 oe outside window", {14'd0, data_oe_hi, data_oe_lo}, 16'd0);
        ior_n = 1'b1;
        @(negedge bus_clk);
        check_read("R8 reg unchanged", 16'h0300, 1'b0);

        // R6 abort during wait
        addr_i = 16'h0306; sbhe_n = 1'b0; data_i = 16'hCAFE; iow_n = 1'b0;
        @(negedge bus_clk);
        chk("R6 ready low in wait", {15'd0, ch_ready_o}, 16'd0);
        iow_n = 1'b1;
        @(negedge bus_clk);
        chk("R6 ready back after abort", {15'd0, ch_ready_o}, 16'd1);
        @(negedge bus_clk);
        check_read("R6 no write on abort", 16'h0306, 1'b0);

        // R9 held strobe after completion stores nothing more
        addr_i = 16'h0308; sbhe_n = 1'b0; data_i = 16'h1111; iow_n = 1'b0;
        w = 0;
        @(negedge bus_clk);
        while (!ch_ready_o && w < 30) begin w++; @(negedge bus_clk); end
        model[4] = 16'h1111;
        data_i = 16'h2222;
        for (int k = 0; k < 4; k++) begin
            @(negedge bus_clk);
            chk("R9 ready stays high while held", {15'd0, ch_ready_o}, 16'd1);
        end
        iow_n = 1'b1;
        @(negedge bus_clk);
        @(negedge bus_clk);
        check_read("R9 single transfer", 16'h0308, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule